// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block is the always-on controller that chooses how an SoC's main domain is clocked and powered. Software picks one of four operating modes by writing a two-bit mode code. The block then drives four control outputs: a core clock enable, a peripheral clock enable, a select that bypasses the PLL and takes the external input clock directly, and an enable for the main-domain power switch. A two-bit status output always shows which mode is in effect.

Two events take the block back to full operation. A peripheral interrupt request ends idle mode at once. The wake pin ends power-down mode, but only in stages. Main power returns first, and both clock enables stay low while a programmable settle count runs down. A change between the PLL clock and the bypass clock is never made while the core clock runs. The block inserts one cycle with the core clock gated, and the clock select changes during that cycle.

The PLL, the clock multiplexer and the analog power switches are outside this block. It only produces their select and enable lines, and it takes the settle count as an input.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, the outputs are: core clock enable 1, peripheral clock enable 1, bypass 0, main power 1, status 0.
- R2: In normal mode (status code 0) both clock enables and main power are 1, and bypass is 0.
- R3: When normal mode takes a write of code 1, the next cycle is a gap cycle: core clock enable 0, bypass 1, status 1. Slow mode follows on the cycle after: core clock enable 1, bypass 1, peripheral clock and power 1, status 1.
- R4: When slow mode takes a write of code 0, the next cycle is a gap cycle: core clock enable 0, bypass 0, status 0. Normal mode follows on the cycle after. The bypass output never changes while the core clock enable is 1.
- R5: A write of code 2 in normal or slow mode enters idle mode on the next cycle: core clock enable 0, peripheral clock enable 1, bypass 0, power 1, status 2.
- R6: An interrupt request seen during idle mode returns the block to normal mode on the next cycle.
- R7: A write of code 3 in normal or slow mode enters power-down on the next cycle: all four control outputs 0, status 3.
- R8: The wake pin seen during power-down sets main power to 1 on the next cycle. Both clock enables then stay 0, with status 3, for settle_cnt+1 cycles. Normal mode follows.
- R9: A mode write is taken only in normal or slow mode. In idle, power-down, settling and gap cycles it is ignored.
- R10: An interrupt request has no effect outside idle mode. The wake pin has no effect outside power-down.
- R11: A write of the code for the mode already in effect changes nothing: the block inserts no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Single-cycle mode write strobe |
| mode_wdata | input | 2 | Requested mode: 0 normal, 1 slow, 2 idle, 3 power-down |
| irq | input | 1 | Peripheral interrupt request |
| wake | input | 1 | Wake pin |
| settle_cnt | input | SETTLE_W | Settle count used on power-down exit |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_bypass | output | 1 | 1 selects the external input clock instead of the PLL |
| main_pwr_en | output | 1 | Main-domain power switch enable |
| mode_stat | output | 2 | Current mode code |

## Verification
The bench targets the gap cycle of a normal/slow change. A design without the gap would change the bypass select while the core clock runs, and one with the wrong gap would show the new select a cycle late or keep the core clock enable low too long. It measures the settling window after power-down exactly: a design that is off by one in the timer, or that enables the clocks together with power, gives the wrong count of cycles with power on and clocks off. It sends writes, interrupts and wake pulses in the modes where each must be ignored, and it rewrites the current mode. A design that filters these wrongly would leave idle or power-down early, or would insert a spurious gap.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_NORMAL = 2'd0,
      MODE_SLOW   = 2'd1,
      MODE_IDLE   = 2'd2,
      MODE_PDOWN  = 2'd3
   } mode_e;

   typedef enum logic [2:0] {
      ST_NORMAL = 3'd0,
      ST_SLOW   = 3'd1,
      ST_IDLE   = 3'd2,
      ST_PDOWN  = 3'd3,
      ST_WAKE   = 3'd4,
      ST_GAP    = 3'd5
   } state_e;

   typedef struct packed {
      logic              core_en;
      logic              periph_en;
      logic              bypass;
      logic              pwr_en;
      logic [MODE_W-1:0] stat;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{core_en: 1'b1, periph_en: 1'b1, bypass: 1'b0,
                                  pwr_en: 1'b1, stat: MODE_NORMAL};
endpackage

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   if (CNT_W < 1) begin : g_bad_width
      $error("pmc_settle_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
   import pmc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [MODE_W-1:0] wdata,
   input  logic              irq,
   input  logic              wake,
   input  logic              timer_done,
   output state_e            state,
   output logic              tgt_slow,
   output logic              timer_load
);
   state_e st_q, st_d;
   logic   tgt_q, tgt_d;

   always_comb begin
      st_d       = st_q;
      tgt_d      = tgt_q;
      timer_load = 1'b0;
      unique case (st_q)
         ST_NORMAL, ST_SLOW: begin
            if (wr) begin
               unique case (mode_e'(wdata))
                  MODE_NORMAL: if (st_q == ST_SLOW) begin
                     st_d  = ST_GAP;
                     tgt_d = 1'b0;
                  end
                  MODE_SLOW: if (st_q == ST_NORMAL) begin
                     st_d  = ST_GAP;
                     tgt_d = 1'b1;
                  end
                  MODE_IDLE:  st_d = ST_IDLE;
                  MODE_PDOWN: st_d = ST_PDOWN;
                  default:    st_d = st_q;
               endcase
            end
         end
         ST_GAP:   st_d = tgt_q ? ST_SLOW : ST_NORMAL;
         ST_IDLE:  if (irq) st_d = ST_NORMAL;
         ST_PDOWN: if (wake) begin
            st_d       = ST_WAKE;
            timer_load = 1'b1;
         end
         ST_WAKE:  if (timer_done) st_d = ST_NORMAL;
         default:  st_d = ST_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_NORMAL;
         tgt_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         tgt_q <= tgt_d;
      end
   end

   assign state    = st_q;
   assign tgt_slow = tgt_q;
endmodule

// File: rtl/pmc_out_decode.sv
module pmc_out_decode
   import pmc_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  state_e state,
   input  logic   tgt_slow,
   output ctl_t   ctl
);
   ctl_t ctl_d;

   always_comb begin
      ctl_d = CTL_RESET;
      unique case (state)
         ST_NORMAL: ctl_d = CTL_RESET;
         ST_SLOW:   begin ctl_d.bypass = 1'b1; ctl_d.stat = MODE_SLOW; end
         ST_GAP:    begin
            ctl_d.core_en = 1'b0;
            ctl_d.bypass  = tgt_slow;
            ctl_d.stat    = tgt_slow ? MODE_SLOW : MODE_NORMAL;
         end
         ST_IDLE:   begin ctl_d.core_en = 1'b0; ctl_d.stat = MODE_IDLE; end
         ST_PDOWN:  begin
            ctl_d.core_en   = 1'b0;
            ctl_d.periph_en = 1'b0;
            ctl_d.pwr_en    = 1'b0;
            ctl_d.stat      = MODE_PDOWN;
         end
         ST_WAKE:   begin
            ctl_d.core_en   = 1'b0;
            ctl_d.periph_en = 1'b0;
            ctl_d.stat      = MODE_PDOWN;
         end
         default:   ctl_d = CTL_RESET;
      endcase
   end

   if (OUT_REG) begin : g_reg_out
      ctl_t ctl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ctl_q <= CTL_RESET;
         else        ctl_q <= ctl_d;
      end
      assign ctl = ctl_q;
   end else begin : g_comb_out
      assign ctl = ctl_d;
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int SETTLE_W = 16,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_wr,
   input  logic [MODE_W-1:0]   mode_wdata,
   input  logic                irq,
   input  logic                wake,
   input  logic [SETTLE_W-1:0] settle_cnt,
   output logic                core_clk_en,
   output logic                periph_clk_en,
   output logic                pll_bypass,
   output logic                main_pwr_en,
   output logic [MODE_W-1:0]   mode_stat
);
   if (SETTLE_W < 1 || SETTLE_W > 32) begin : g_bad_settle
      $error("pwr_mode_ctrl: SETTLE_W must be in 1..32");
   end

   state_e st;
   logic   tgt_slow, t_load, t_done;
   ctl_t   ctl;

   pmc_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(settle_cnt), .done(t_done)
   );

   pmc_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wdata(mode_wdata), .irq(irq),
      .wake(wake), .timer_done(t_done), .state(st), .tgt_slow(tgt_slow),
      .timer_load(t_load)
   );

   pmc_out_decode #(.OUT_REG(OUT_REG)) u_dec (
      .clk(clk), .rst_n(rst_n), .state(st), .tgt_slow(tgt_slow), .ctl(ctl)
   );

   assign core_clk_en   = ctl.core_en;
   assign periph_clk_en = ctl.periph_en;
   assign pll_bypass    = ctl.bypass;
   assign main_pwr_en   = ctl.pwr_en;
   assign mode_stat     = ctl.stat;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_wr,
   input logic       irq,
   input logic       wake,
   input logic       core_clk_en,
   input logic       periph_clk_en,
   input logic       pll_bypass,
   input logic       main_pwr_en,
   input logic [1:0] mode_stat
);
   assert_clk_needs_pwr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en || periph_clk_en) |-> main_pwr_en);

   assert_mux_change_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pll_bypass) |-> !core_clk_en);

   assert_slow_uses_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd1) |-> pll_bypass);

   assert_idle_gating_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd2) |-> (!core_clk_en && periph_clk_en && main_pwr_en));

   assert_irq_leaves_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd2 && irq) |=> (mode_stat == 2'd0 && core_clk_en));

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd2 && !irq) |=> (mode_stat == 2'd2));

   assert_pdown_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd3 && !main_pwr_en && !wake) |=> (mode_stat == 2'd3 && !main_pwr_en));

   assert_power_before_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_pwr_en) |-> (!core_clk_en && !periph_clk_en && mode_stat == 2'd3));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .irq(irq), .wake(wake),
   .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .pll_bypass(pll_bypass),
   .main_pwr_en(main_pwr_en), .mode_stat(mode_stat)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [1:0]  mode_wdata = 2'd0;
   logic        irq = 1'b0;
   logic        wake = 1'b0;
   logic [15:0] settle_cnt = 16'd0;
   logic        core_clk_en, periph_clk_en, pll_bypass, main_pwr_en;
   logic [1:0]  mode_stat;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // model states: 0 normal, 1 slow, 2 idle, 3 power-down, 4 settling, 5 gap
   int          m_st = 0;
   logic        m_tgt = 1'b0;
   int unsigned m_cnt = 0;

   always #4 clk = ~clk;

   pwr_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata), .irq(irq),
      .wake(wake), .settle_cnt(settle_cnt), .core_clk_en(core_clk_en),
      .periph_clk_en(periph_clk_en), .pll_bypass(pll_bypass), .main_pwr_en(main_pwr_en),
      .mode_stat(mode_stat)
   );

   // packed as {core, periph, bypass, power, status[1:0]}
   function automatic logic [5:0] act_out();
      return {core_clk_en, periph_clk_en, pll_bypass, main_pwr_en, mode_stat};
   endfunction

   function automatic logic [5:0] exp_out(input int st, input logic tgt);
      case (st)
         0:       return 6'b1101_00;
         1:       return 6'b1111_01;
         2:       return 6'b0101_10;
         3:       return 6'b0000_11;
         4:       return 6'b0001_11;
         default: return tgt ? 6'b0111_01 : 6'b0101_00;
      endcase
   endfunction

   function automatic string st_tag(input int st);
      case (st)
         0:       return "R2";
         1:       return "R3";
         2:       return "R5";
         3:       return "R7";
         4:       return "R8";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [5:0] a, input logic [5:0] e);
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, a, e);
      end
   endtask

   task automatic model_step(input logic w, input logic [1:0] d, input logic i, input logic wk);
      case (m_st)
         0, 1: if (w) begin
            if (d == 2'd2) m_st = 2;
            else if (d == 2'd3) m_st = 3;
            else if (int'(d) != m_st) begin m_tgt = d[0]; m_st = 5; end
         end
         2: if (i) m_st = 0;
         3: if (wk) begin m_st = 4; m_cnt = settle_cnt; end
         4: if (m_cnt == 0) m_st = 0; else m_cnt--;
         default: m_st = m_tgt ? 1 : 0;
      endcase
   endtask

   // called at a negedge; returns at the next negedge after comparing
   task automatic step(input logic w, input logic [1:0] d, input logic i, input logic wk);
      mode_wr = w; mode_wdata = d; irq = i; wake = wk;
      @(posedge clk);
      model_step(w, d, i, wk);
      @(negedge clk);
      mode_wr = 1'b0; irq = 1'b0; wake = 1'b0;
      chk(st_tag(m_st), act_out(), exp_out(m_st, m_tgt));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int wake_cycles;
      void'($urandom(32'd7351));
      repeat (3) @(negedge clk);
      chk("R1 in reset", act_out(), 6'b1101_00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", act_out(), 6'b1101_00);

      // R11: rewrite normal, no gap
      step(1'b1, 2'd0, 1'b0, 1'b0);
      chk("R11 same-mode write", act_out(), 6'b1101_00);
      // R3: normal -> slow through a gap
      step(1'b1, 2'd1, 1'b0, 1'b0);
      chk("R3 gap", act_out(), 6'b0111_01);
      step(1'b0, 2'd0, 1'b0, 1'b0);
      chk("R3 slow", act_out(), 6'b1111_01);
      step(1'b1, 2'd1, 1'b0, 1'b0);
      chk("R11 slow rewrite", act_out(), 6'b1111_01);
      step(1'b0, 2'd0, 1'b1, 1'b1);
      chk("R10 irq/wake in slow", act_out(), 6'b1111_01);
      // R4: slow -> normal; write during gap ignored (R9)
      step(1'b1, 2'd0, 1'b0, 1'b0);
      chk("R4 gap", act_out(), 6'b0101_00);
      step(1'b1, 2'd3, 1'b0, 1'b0);
      chk("R9 write in gap", act_out(), 6'b1101_00);
      // R5/R6 idle
      step(1'b1, 2'd2, 1'b0, 1'b0);
      chk("R5 idle", act_out(), 6'b0101_10);
      step(1'b1, 2'd3, 1'b0, 1'b0);
      chk("R9 write in idle", act_out(), 6'b0101_10);
      step(1'b0, 2'd0, 1'b0, 1'b1);
      chk("R10 wake in idle", act_out(), 6'b0101_10);
      step(1'b0, 2'd0, 1'b1, 1'b0);
      chk("R6 irq exits idle", act_out(), 6'b1101_00);
      // R7/R8 power-down with a long settle
      settle_cnt = 16'd300;
      step(1'b1, 2'd3, 1'b0, 1'b0);
      chk("R7 power-down", act_out(), 6'b0000_11);
      step(1'b1, 2'd0, 1'b1, 1'b0);
      chk("R9 R10 write/irq in power-down", act_out(), 6'b0000_11);
      step(1'b0, 2'd0, 1'b0, 1'b1);
      chk("R8 power first", act_out(), 6'b0001_11);
      wake_cycles = 1;
      while (!core_clk_en && wake_cycles < 1000) begin
         step(1'b0, 2'd0, 1'b0, 1'b0);
         if (!core_clk_en) wake_cycles++;
      end
      chk("R8 settle length", 6'(wake_cycles == 301), 6'd1);
      chk("R8 back to normal", act_out(), 6'b1101_00);
      // R8 with zero settle: one cycle of power-only, slow entry from pdown write
      settle_cnt = 16'd0;
      step(1'b1, 2'd1, 1'b0, 1'b0);
      step(1'b0, 2'd0, 1'b0, 1'b0);
      step(1'b1, 2'd3, 1'b0, 1'b0);
      step(1'b0, 2'd0, 1'b0, 1'b1);
      chk("R8 zero settle", act_out(), 6'b0001_11);
      step(1'b1, 2'd2, 1'b0, 1'b0);
      chk("R8 R9 zero settle exit", act_out(), 6'b1101_00);

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         logic w, i, wk;
         logic [1:0] d;
         if (n % 50 == 0) settle_cnt = 16'($urandom % 8);
         w  = ($urandom % 4) == 0;
         d  = 2'($urandom % 4);
         i  = ($urandom % 8) == 0;
         wk = ($urandom % 6) == 0;
         step(w, d, i, wk);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule